// File: doc/BRIEF.md
# Double-Rate Read Burst Scheduler

This block generates the read-data timing of a double-data-rate memory device. A read command is taken on a rising clock edge together with a column address, a latency setting, a burst length setting and a burst ordering select. After the programmed read latency, the block delivers the burst one beat per half clock. Each clock cycle therefore has a rising-half lane and a falling-half lane, and each lane has its own data, valid and strobe output. The strobe level changes with every beat, so its transitions line up with the data.

Latency is tracked in half-clock slots. A setting of two and a half clocks starts the burst in a falling-half lane. Each beat's data comes from a fixed pattern generator: the column address of the beat XORed with a constant. A read that arrives while earlier bursts are still pending is placed directly after them, so data always leaves in command order. A command with a reserved setting, or one that cannot fit in the pending-slot window, produces no data and raises an error pulse.

Top module: `ddr_rd_sched`

## Requirements
- R1: While reset is held and directly after it, every valid, strobe and data output is low and the error output is low.
- R2: With lat_sel = 2'b00 (two clocks), a read taken at rising edge n shows its first beat in the rising-half lane of the cycle that follows edge n+2.
- R3: With lat_sel = 2'b01 (two and a half clocks), the first beat appears in the falling-half lane of the cycle that follows edge n+2.
- R4: With lat_sel = 2'b10 (three clocks), the first beat appears in the rising-half lane of the cycle that follows edge n+3.
- R5: bl_sel = 2'b01, 2'b10 and 2'b11 give bursts of 2, 4 and 8 beats. These beats occupy consecutive half-clock lanes, and no other lane is valid.
- R6: With burst_ilv = 0, beat i addresses column (s + i) mod B within the aligned block of B columns that holds the start column. Here s is the start column's offset in that block. Higher column bits stay unchanged.
- R7: With burst_ilv = 1, beat i addresses offset s XOR i within the same aligned block.
- R8: A valid lane carries PATTERN XOR the beat's column address, zero-extended to the data width (PATTERN defaults to 16'hA500). An invalid lane carries zero.
- R9: A lane's strobe is high on beats with an even index within their burst and low on odd beats and on invalid lanes. It therefore alternates across every pair of consecutive valid lanes.
- R10: Reads with equal latency spaced B/2 clocks apart produce back-to-back bursts with no empty lane between them, in command order.
- R11: A read whose latency slot is still occupied by earlier bursts starts in the first half-clock slot after the last pending beat.
- R12: A read with lat_sel = 2'b11 or bl_sel = 2'b00 produces no beats. It raises rd_err for exactly the cycle that follows its edge.
- R13: A read whose last beat would lie NSLOT or more half-clock slots after its command edge is rejected in the same way: no beats, and an rd_err pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; commands taken on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_cmd | input | 1 | Read command strobe |
| rd_col | input | COL_W | Start column address |
| lat_sel | input | 2 | Latency: 00 two, 01 two and a half, 10 three clocks, 11 reserved |
| bl_sel | input | 2 | Burst length: 01 two, 10 four, 11 eight beats, 00 reserved |
| burst_ilv | input | 1 | 0 sequential, 1 interleaved beat order |
| dq_rise | output | DATA_W | Data of the rising-half lane |
| dq_fall | output | DATA_W | Data of the falling-half lane |
| dv_rise | output | 1 | Rising-half lane holds a beat |
| dv_fall | output | 1 | Falling-half lane holds a beat |
| dqs_rise | output | 1 | Strobe level in the rising-half lane |
| dqs_fall | output | 1 | Strobe level in the falling-half lane |
| rd_err | output | 1 | One-cycle pulse for a rejected read |

## Verification
The hardest situation to reach from the ports is a full pending window. It needs more outstanding eight-beat bursts than the latency alone ever creates. The stimulus issues eight-beat reads on five consecutive edges, so the queued end point moves three clocks further out on every edge until the fifth read no longer fits. Queueing across a latency change is reached the same way. A long-latency burst is followed one clock later by a short-latency read, which must wait behind it and may start in a falling-half lane.

// File: rtl/ddr_rd_pkg.sv
package ddr_rd_pkg;

  typedef enum logic [1:0] {
    LAT_2_0  = 2'b00,
    LAT_2_5  = 2'b01,
    LAT_3_0  = 2'b10,
    LAT_RSVD = 2'b11
  } lat_e;

  typedef enum logic [1:0] {
    BL_RSVD = 2'b00,
    BL_2    = 2'b01,
    BL_4    = 2'b10,
    BL_8    = 2'b11
  } bl_e;

  // Latency in half-clock slots; zero marks a reserved code.
  function automatic logic [2:0] lat_halves(logic [1:0] sel);
    case (sel)
      LAT_2_0: return 3'd4;
      LAT_2_5: return 3'd5;
      LAT_3_0: return 3'd6;
      default: return 3'd0;
    endcase
  endfunction

  // Beats per burst; zero marks a reserved code.
  function automatic logic [3:0] bl_beats(logic [1:0] sel);
    case (sel)
      BL_2:    return 4'd2;
      BL_4:    return 4'd4;
      BL_8:    return 4'd8;
      default: return 4'd0;
    endcase
  endfunction

  // Low three column bits of beat idx, wrapping inside the aligned block.
  function automatic logic [2:0] beat_low(logic [2:0] s, logic [2:0] idx,
                                          logic [3:0] blen, logic ilv);
    logic [2:0] mask;
    mask = blen[2:0] - 3'd1;
    if (ilv) return s ^ (idx & mask);
    return ((s + idx) & mask) | (s & ~mask);
  endfunction

endpackage

// File: rtl/rd_cmd_decode.sv
module rd_cmd_decode
  import ddr_rd_pkg::*;
#(
  parameter int NSLOT = 32,
  localparam int SW = $clog2(NSLOT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_cmd,
  input  logic [1:0]    lat_sel,
  input  logic [1:0]    bl_sel,
  output logic          accept,
  output logic [SW-1:0] start_rel,
  output logic [3:0]    blen,
  output logic          err
);

  logic [SW-1:0] end_q, end_d, base;
  logic [SW:0]   stop;
  logic [2:0]    lat_h;
  logic          fits, cmd_ok, err_d, end_en;

  // Next-state: place the burst after the later of latency and pending tail.
  always_comb begin
    lat_h     = lat_halves(lat_sel);
    blen      = bl_beats(bl_sel);
    base      = (end_q > SW'(2)) ? end_q - SW'(2) : '0;
    start_rel = (base > SW'(lat_h)) ? base : SW'(lat_h);
    stop      = {1'b0, start_rel} + (SW+1)'(blen);
    fits      = stop <= (SW+1)'(NSLOT);
    cmd_ok    = (lat_h != 3'd0) && (blen != 4'd0) && fits;
    accept    = rd_cmd && cmd_ok;
    err_d     = rd_cmd && !cmd_ok;
    end_d     = accept ? stop[SW-1:0] : base;
    end_en    = accept || (end_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_q <= '0;
      err   <= 1'b0;
    end else begin
      if (end_en) end_q <= end_d;
      err <= err_d;
    end
  end

  // R12: a reserved latency code is flagged in the next cycle
  a_r12_reserved_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd && lat_sel == LAT_RSVD) |=> err);

endmodule

// File: rtl/rd_slot_line.sv
module rd_slot_line
  import ddr_rd_pkg::*;
#(
  parameter int NSLOT = 32,
  parameter int COL_W = 10,
  localparam int SW = $clog2(NSLOT + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      accept,
  input  logic [SW-1:0]             start_rel,
  input  logic [3:0]                blen,
  input  logic [COL_W-1:0]          base_col,
  input  logic                      ilv,
  output logic [1:0]                lane_vld,
  output logic [1:0]                lane_odd,
  output logic [1:0][COL_W-1:0]     lane_col
);

  logic [NSLOT-1:0]             vld_q, vld_d, odd_q, odd_d, hit, shv;
  logic [NSLOT-1:0][COL_W-1:0]  col_q, col_d;

  // Slot t holds half-clock 2k+t; every clock the line advances by two.
  for (genvar t = 0; t < NSLOT; t++) begin : g_slot
    localparam int         TI  = t;
    localparam logic [2:0] TLO = 3'(TI);
    logic             sh_odd;
    logic [COL_W-1:0] sh_col;
    logic [2:0]       idx;

    if (t + 2 < NSLOT) begin : g_shift
      assign shv[t]  = vld_q[t+2];
      assign sh_odd  = odd_q[t+2];
      assign sh_col  = col_q[t+2];
    end else begin : g_tail
      assign shv[t]  = 1'b0;
      assign sh_odd  = 1'b0;
      assign sh_col  = '0;
    end

    assign hit[t]   = accept && ((SW+1)'(TI) >= {1'b0, start_rel})
                             && ((SW+1)'(TI) < {1'b0, start_rel} + (SW+1)'(blen));
    assign idx      = TLO - start_rel[2:0];
    assign vld_d[t] = hit[t] | shv[t];
    assign odd_d[t] = hit[t] ? idx[0] : sh_odd;
    assign col_d[t] = hit[t] ? {base_col[COL_W-1:3], beat_low(base_col[2:0], idx, blen, ilv)}
                             : sh_col;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      odd_q <= '0;
      col_q <= '0;
    end else begin
      vld_q <= vld_d;
      odd_q <= odd_d;
      col_q <= col_d;
    end
  end

  assign lane_vld = vld_q[1:0];
  assign lane_odd = odd_q[1:0];
  assign lane_col = col_q[1:0];

  // R11: a newly placed burst never lands on a slot that is still pending
  a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (hit & shv) == '0);

  // R2: no accepted read starts earlier than two clocks after its edge
  a_r2_min_latency: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (start_rel >= SW'(4)));

endmodule

// File: rtl/rd_beat_out.sv
module rd_beat_out #(
  parameter int                COL_W   = 10,
  parameter int                DATA_W  = 16,
  parameter logic [DATA_W-1:0] PATTERN = 16'hA500
) (
  input  logic              vld,
  input  logic              odd,
  input  logic [COL_W-1:0]  col,
  output logic [DATA_W-1:0] dq,
  output logic              dv,
  output logic              dqs
);

  assign dv  = vld;
  assign dqs = vld & ~odd;
  assign dq  = vld ? (PATTERN ^ DATA_W'(col)) : '0;

endmodule

// File: rtl/ddr_rd_sched.sv
module ddr_rd_sched #(
  parameter int                COL_W   = 10,
  parameter int                DATA_W  = 16,
  parameter int                NSLOT   = 32,
  parameter logic [DATA_W-1:0] PATTERN = 16'hA500,
  localparam int SW = $clog2(NSLOT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_cmd,
  input  logic [COL_W-1:0]  rd_col,
  input  logic [1:0]        lat_sel,
  input  logic [1:0]        bl_sel,
  input  logic              burst_ilv,
  output logic [DATA_W-1:0] dq_rise,
  output logic [DATA_W-1:0] dq_fall,
  output logic              dv_rise,
  output logic              dv_fall,
  output logic              dqs_rise,
  output logic              dqs_fall,
  output logic              rd_err
);

  logic                     accept;
  logic [SW-1:0]            start_rel;
  logic [3:0]               blen;
  logic [1:0]               lane_vld, lane_odd, lane_dv, lane_dqs;
  logic [1:0][COL_W-1:0]    lane_col;
  logic [1:0][DATA_W-1:0]   lane_dq;

  rd_cmd_decode #(.NSLOT(NSLOT)) u_dec (
    .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .lat_sel(lat_sel), .bl_sel(bl_sel),
    .accept(accept), .start_rel(start_rel), .blen(blen), .err(rd_err)
  );

  rd_slot_line #(.NSLOT(NSLOT), .COL_W(COL_W)) u_line (
    .clk(clk), .rst_n(rst_n), .accept(accept), .start_rel(start_rel), .blen(blen),
    .base_col(rd_col), .ilv(burst_ilv),
    .lane_vld(lane_vld), .lane_odd(lane_odd), .lane_col(lane_col)
  );

  // Lane 0 is the rising half of the cycle, lane 1 the falling half.
  for (genvar l = 0; l < 2; l++) begin : g_lane
    rd_beat_out #(.COL_W(COL_W), .DATA_W(DATA_W), .PATTERN(PATTERN)) u_out (
      .vld(lane_vld[l]), .odd(lane_odd[l]), .col(lane_col[l]),
      .dq(lane_dq[l]), .dv(lane_dv[l]), .dqs(lane_dqs[l])
    );
  end

  assign dq_rise  = lane_dq[0];
  assign dq_fall  = lane_dq[1];
  assign dv_rise  = lane_dv[0];
  assign dv_fall  = lane_dv[1];
  assign dqs_rise = lane_dqs[0];
  assign dqs_fall = lane_dqs[1];

  // R9: strobe alternates between the two halves of a cycle
  a_r9_strobe_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (dv_rise && dv_fall) |-> (dqs_rise != dqs_fall));

  // R9: strobe alternates from a falling half into the next rising half
  a_r9_strobe_cross: assert property (@(posedge clk) disable iff (!rst_n)
    dv_fall |=> (dv_rise -> (dqs_rise != $past(dqs_fall))));

endmodule

// File: tb/tb_ddr_rd_sched.sv
`timescale 1ns/1ps
module tb_ddr_rd_sched;

  localparam int          COL_W   = 10;
  localparam int          DATA_W  = 16;
  localparam int          NSLOT   = 32;
  localparam logic [15:0] PATTERN = 16'hA500;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              rd_cmd;
  logic [COL_W-1:0]  rd_col;
  logic [1:0]        lat_sel, bl_sel;
  logic              burst_ilv;
  logic [DATA_W-1:0] dq_rise, dq_fall;
  logic              dv_rise, dv_fall, dqs_rise, dqs_fall, rd_err;

  ddr_rd_sched dut (
    .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .rd_col(rd_col), .lat_sel(lat_sel),
    .bl_sel(bl_sel), .burst_ilv(burst_ilv), .dq_rise(dq_rise), .dq_fall(dq_fall),
    .dv_rise(dv_rise), .dv_fall(dv_fall), .dqs_rise(dqs_rise), .dqs_fall(dqs_fall),
    .rd_err(rd_err)
  );

  always #2.5 clk = ~clk;

  typedef struct packed {
    int               slot;
    logic [DATA_W-1:0] data;
    logic             strb;
  } beat_t;

  beat_t expq[$];
  string tagq[$];
  bit    err_exp[int];
  string err_tag[int];
  string idle_tag = "R1";
  int    ecount = 0;
  bit    running = 0;
  bit    done = 0;
  int    checks = 0;
  int    fails = 0;
  int    next_free = 0;
  int    wd = 0;

  always @(posedge clk) if (running) ecount <= ecount + 1;

  // Column of beat i as R6/R7 define the ordering.
  function automatic int exp_col(int col, int i, int beats, bit ilv);
    int s, blk, lo;
    s   = col % beats;
    blk = col - s;
    lo  = ilv ? (s ^ i) : ((s + i) % beats);
    return blk + lo;
  endfunction

  // Driver: present one read for the next rising edge and record what it owes.
  task automatic issue(int lat, int bl, bit ilv, int col, string tag);
    int n, halves, beats, start;
    @(negedge clk);
    rd_cmd = 1'b1; lat_sel = 2'(lat); bl_sel = 2'(bl); burst_ilv = ilv; rd_col = COL_W'(col);
    n      = ecount + 1;
    halves = (lat == 0) ? 4 : (lat == 1) ? 5 : (lat == 2) ? 6 : -1;
    beats  = (bl == 1) ? 2 : (bl == 2) ? 4 : (bl == 3) ? 8 : -1;
    if (halves < 0 || beats < 0) begin
      err_exp[n] = 1'b1; err_tag[n] = tag;
      return;
    end
    start = (2*n + halves > next_free) ? 2*n + halves : next_free;
    if (start + beats > 2*n + NSLOT) begin
      err_exp[n] = 1'b1; err_tag[n] = tag;
      return;
    end
    for (int i = 0; i < beats; i++) begin
      beat_t b;
      b.slot = start + i;
      b.data = PATTERN ^ 16'(exp_col(col, i, beats, ilv));
      b.strb = (i % 2 == 0);
      expq.push_back(b);
      tagq.push_back(tag);
    end
    next_free = start + beats;
  endtask

  task automatic idle(int k);
    @(negedge clk);
    rd_cmd = 1'b0;
    repeat (k - 1) @(negedge clk);
  endtask

  task automatic check_lane(int slot, logic v, logic s, logic [DATA_W-1:0] d);
    logic [DATA_W+1:0] got, exp;
    string tag;
    got = {v, s, d};
    if (expq.size() > 0 && expq[0].slot == slot) begin
      exp = {1'b1, expq[0].strb, expq[0].data};
      tag = tagq[0];
      void'(expq.pop_front());
      void'(tagq.pop_front());
    end else begin
      exp = '0;
      tag = idle_tag;
    end
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s slot %0d got {dv,dqs,dq}=%h exp=%h", tag, slot, got, exp);
    end
  endtask

  // Monitor: after edge k the lanes show half-slots 2k and 2k+1.
  always @(negedge clk) begin
    if (running && !done) begin
      int k;
      bit e;
      k = ecount;
      check_lane(2*k, dv_rise, dqs_rise, dq_rise);
      check_lane(2*k + 1, dv_fall, dqs_fall, dq_fall);
      e = err_exp.exists(k);
      checks++;
      if (rd_err !== e) begin
        fails++;
        $display("FAIL %s rd_err after edge %0d got=%b exp=%b", e ? err_tag[k] : idle_tag, k, rd_err, e);
      end
    end
  end

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd == 20000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL R10 watchdog expired got=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rd_cmd = 1'b0; rd_col = '0; lat_sel = 2'b00; bl_sel = 2'b01; burst_ilv = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    checks++;
    if ({dv_rise, dv_fall, dqs_rise, dqs_fall, rd_err, dq_rise, dq_fall} !== '0) begin
      fails++;
      $display("FAIL R1 reset outputs got=%h exp=0",
               {dv_rise, dv_fall, dqs_rise, dqs_fall, rd_err, dq_rise, dq_fall});
    end
    rst_n = 1'b1; running = 1'b1;
    idle(4);

    idle_tag = "R2";  issue(0, 1, 0, 10'h005, "R2"); idle(8);
    idle_tag = "R3";  issue(1, 2, 0, 10'h00E, "R3"); idle(8);
    idle_tag = "R4";  issue(2, 3, 1, 10'h1F3, "R4"); idle(10);
    idle_tag = "R5";  issue(0, 3, 0, 10'h000, "R5"); idle(10);
    idle_tag = "R6";  issue(1, 3, 0, 10'h0A5, "R6"); idle(10);
    idle_tag = "R7";  issue(0, 2, 1, 10'h2B1, "R7"); idle(8);
    idle_tag = "R8";  issue(2, 1, 0, 10'h3FF, "R8"); idle(8);
    // R10 and R9: gapless strobe across bursts spaced B/2 clocks
    idle_tag = "R10";
    issue(0, 2, 0, 10'h010, "R10"); idle(1);
    issue(0, 2, 1, 10'h023, "R10"); idle(1);
    issue(0, 2, 0, 10'h036, "R10"); idle(10);
    issue(1, 1, 0, 10'h041, "R9");  issue(1, 1, 0, 10'h052, "R9"); idle(8);
    // R11: queued behind a pending burst, including a shorter latency
    idle_tag = "R11";
    issue(1, 3, 0, 10'h060, "R11"); issue(0, 1, 0, 10'h071, "R11"); idle(12);
    issue(2, 1, 0, 10'h080, "R11"); issue(0, 1, 1, 10'h093, "R11"); idle(8);
    // R12: reserved codes
    idle_tag = "R12";
    issue(3, 1, 0, 10'h005, "R12"); idle(8);
    issue(0, 0, 0, 10'h005, "R12"); idle(8);
    // R13: window overflow after four queued eight-beat reads
    idle_tag = "R13";
    for (int j = 0; j < 5; j++) issue(0, 3, 0, 10'h100 + 8*j, "R13");
    idle(30);

    checks++;
    if (expq.size() != 0) begin
      fails++;
      $display("FAIL R5 undelivered beats got=%0d exp=0", expq.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule